// File: doc/BRIEF.md
# Processor Power Mode Controller

This block chooses the low-power state of a processor core. Software sets a power-enable bit through a one-cycle configuration write. Three mode-select inputs, for doze, nap and sleep, come from the core's hardware configuration register. Once the power-enable bit is set, the controller moves the core into the selected mode. Before it enters sleep it completes a quiesce request/acknowledge handshake with system logic. In every state it drives enables that show which clock domains stay alive: the core clock, the PLL, the time base and the snoop logic.

Wake-up comes from an external interrupt, a system-management interrupt or a core reset request. Any of these returns the block to run mode and clears the power-enable bit. A separate dynamic power management enable marks idle functional units as low-power. That path does not depend on the power-enable bit or on the current mode.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After synchronous reset the state code is 0 (run), `pwr_en` is 0, `quiesce_req` is 0, all four domain enables are 1 and `unit_lowpwr` is all zero.
- R2: While `pwr_en` is 0 the state stays at run whatever the mode-select inputs are. A write with `cfg_we`=1 loads `cfg_pwr_en` into `pwr_en` at the next clock edge.
- R3: From run with `pwr_en`=1 and doze as the selected mode, the next edge enters doze (code 1). In doze the core clock enable is 0 and the PLL, time base and snoop enables are 1.
- R4: With nap selected, the block spends ENTRY_DELAY cycles in nap-entry (code 2) and then enters nap (code 3). In nap the core clock and snoop enables are 0 and the PLL and time base enables are 1.
- R5: With sleep selected, the next edge moves the block to quiesce-wait (code 4) and raises `quiesce_req`. It stays there with all domains enabled for as long as `quiesce_ack` is low.
- R6: When `quiesce_ack` is seen in quiesce-wait, the block spends ENTRY_DELAY cycles in sleep-entry (code 5) and then enters sleep (code 6). In sleep all four domain enables are 0. `quiesce_req` stays high through sleep-entry and sleep.
- R7: When several mode-select inputs are high, sleep wins over nap and nap wins over doze. With none high the block stays in run.
- R8: `ext_irq`, `smi_irq` or `core_reset_req` high at an edge forces run (code 0) and clears `pwr_en` at that edge, from any state. This includes an abort during the sleep handshake. A wake event also takes priority over a configuration write in the same cycle.
- R9: `unit_lowpwr[i]` equals `dpm_en & unit_idle[i]` sampled at the previous edge. This holds independently of `pwr_en` and of the power state.
- R10: Once entered, doze, nap and sleep are held until a wake event, even if the mode-select inputs or `pwr_en` writes change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the power-enable bit |
| cfg_pwr_en | input | 1 | Value written to the power-enable bit |
| sel_doze | input | 1 | Doze mode select |
| sel_nap | input | 1 | Nap mode select |
| sel_sleep | input | 1 | Sleep mode select |
| quiesce_ack | input | 1 | System acknowledge that the core may sleep |
| ext_irq | input | 1 | External interrupt wake source |
| smi_irq | input | 1 | System-management interrupt wake source |
| core_reset_req | input | 1 | Reset request wake source |
| dpm_en | input | 1 | Dynamic power management enable |
| unit_idle | input | NUM_UNITS | Idle flag per functional unit |
| pm_state | output | 3 | State code: 0 run, 1 doze, 2 nap-entry, 3 nap, 4 quiesce-wait, 5 sleep-entry, 6 sleep |
| pwr_en | output | 1 | Current power-enable bit |
| quiesce_req | output | 1 | Quiesce request to system logic |
| core_clk_en | output | 1 | Core clock domain enable |
| pll_en | output | 1 | PLL enable |
| tbase_en | output | 1 | Time base enable |
| snoop_en | output | 1 | Snoop logic enable |
| unit_lowpwr | output | NUM_UNITS | Low-power indication per functional unit |

## Verification
A configuration write shows up on `pwr_en` one edge later, and the state leaves run one edge after that. Nap and sleep then spend exactly ENTRY_DELAY cycles in their entry states, counted from the edge that entered nap-entry or that sampled the acknowledge. Wake events and dynamic power indications take effect at the next edge. The domain enables and `quiesce_req` are decoded directly from the state, so they change together with the state code. The bench drives and samples on the falling edge and steps an exact number of rising edges before each check. The nap and sleep tests check the last entry cycle and the first cycle of the final mode, so a delay that is one cycle short or one cycle long is caught.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [2:0] {
        PM_RUN        = 3'd0,
        PM_DOZE       = 3'd1,
        PM_NAP_ENTRY  = 3'd2,
        PM_NAP        = 3'd3,
        PM_QWAIT      = 3'd4,
        PM_SLEEP_ENTRY = 3'd5,
        PM_SLEEP      = 3'd6
    } pm_state_e;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_DOZE  = 2'd1,
        TGT_NAP   = 2'd2,
        TGT_SLEEP = 2'd3
    } pm_target_e;

    typedef struct packed {
        logic core;
        logic pll;
        logic tbase;
        logic snoop;
    } pm_domains_t;

    // Priority: sleep, then nap, then doze.
    function automatic pm_target_e pick_target(input logic doze, input logic nap,
                                               input logic sleep);
        if (sleep)     return TGT_SLEEP;
        else if (nap)  return TGT_NAP;
        else if (doze) return TGT_DOZE;
        else           return TGT_NONE;
    endfunction

    function automatic pm_domains_t domains_for(input pm_state_e st);
        pm_domains_t d;
        d = '{core: 1'b1, pll: 1'b1, tbase: 1'b1, snoop: 1'b1};
        case (st)
            PM_DOZE:  d.core = 1'b0;
            PM_NAP: begin
                d.core  = 1'b0;
                d.snoop = 1'b0;
            end
            PM_SLEEP: d = '{core: 1'b0, pll: 1'b0, tbase: 1'b0, snoop: 1'b0};
            default:  ;
        endcase
        return d;
    endfunction

    function automatic logic wants_quiesce(input pm_state_e st);
        return (st == PM_QWAIT) || (st == PM_SLEEP_ENTRY) || (st == PM_SLEEP);
    endfunction

endpackage

// File: rtl/pm_mode_select.sv
module pm_mode_select
    import pwr_mode_pkg::*;
(
    input  logic       sel_doze,
    input  logic       sel_nap,
    input  logic       sel_sleep,
    input  logic       ext_irq,
    input  logic       smi_irq,
    input  logic       core_reset_req,
    output pm_target_e target,
    output logic       wake
);
    always_comb begin
        target = pick_target(sel_doze, sel_nap, sel_sleep);
        wake   = ext_irq | smi_irq | core_reset_req;
    end
endmodule

// File: rtl/pm_sequencer.sv
module pm_sequencer
    import pwr_mode_pkg::*;
#(
    parameter int ENTRY_DELAY = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic       cfg_pwr_en,
    input  pm_target_e target,
    input  logic       wake,
    input  logic       quiesce_ack,
    output pm_state_e  state,
    output logic       pwr_en
);
    localparam int CW = (ENTRY_DELAY > 1) ? $clog2(ENTRY_DELAY) : 1;
    localparam logic [CW-1:0] LAST = CW'(ENTRY_DELAY - 1);

    pm_state_e      state_n;
    logic [CW-1:0]  cnt, cnt_n;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        case (state)
            PM_RUN: begin
                if (pwr_en) begin
                    case (target)
                        TGT_DOZE:  state_n = PM_DOZE;
                        TGT_NAP: begin
                            state_n = PM_NAP_ENTRY;
                            cnt_n   = '0;
                        end
                        TGT_SLEEP: state_n = PM_QWAIT;
                        default:   state_n = PM_RUN;
                    endcase
                end
            end
            PM_NAP_ENTRY: begin
                if (cnt == LAST) state_n = PM_NAP;
                else             cnt_n   = cnt + CW'(1);
            end
            PM_QWAIT: begin
                if (quiesce_ack) begin
                    state_n = PM_SLEEP_ENTRY;
                    cnt_n   = '0;
                end
            end
            PM_SLEEP_ENTRY: begin
                if (cnt == LAST) state_n = PM_SLEEP;
                else             cnt_n   = cnt + CW'(1);
            end
            default: ;
        endcase
        if (wake) begin
            state_n = PM_RUN;
            cnt_n   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= PM_RUN;
            cnt    <= '0;
            pwr_en <= 1'b0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            if (wake)        pwr_en <= 1'b0;
            else if (cfg_we) pwr_en <= cfg_pwr_en;
        end
    end
endmodule

// File: rtl/pm_domain_decode.sv
module pm_domain_decode
    import pwr_mode_pkg::*;
(
    input  pm_state_e   state,
    output pm_domains_t dom,
    output logic        quiesce_req
);
    always_comb begin
        dom         = domains_for(state);
        quiesce_req = wants_quiesce(state);
    end
endmodule

// File: rtl/pm_dpm_gate.sv
module pm_dpm_gate #(
    parameter int NUM_UNITS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dpm_en,
    input  logic [NUM_UNITS-1:0] unit_idle,
    output logic [NUM_UNITS-1:0] unit_lowpwr
);
    for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
        always_ff @(posedge clk) begin
            if (rst) unit_lowpwr[i] <= 1'b0;
            else     unit_lowpwr[i] <= dpm_en & unit_idle[i];
        end
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int NUM_UNITS   = 4,
    parameter int ENTRY_DELAY = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic                 cfg_pwr_en,
    input  logic                 sel_doze,
    input  logic                 sel_nap,
    input  logic                 sel_sleep,
    input  logic                 quiesce_ack,
    input  logic                 ext_irq,
    input  logic                 smi_irq,
    input  logic                 core_reset_req,
    input  logic                 dpm_en,
    input  logic [NUM_UNITS-1:0] unit_idle,
    output logic [2:0]           pm_state,
    output logic                 pwr_en,
    output logic                 quiesce_req,
    output logic                 core_clk_en,
    output logic                 pll_en,
    output logic                 tbase_en,
    output logic                 snoop_en,
    output logic [NUM_UNITS-1:0] unit_lowpwr
);
    pm_target_e  target;
    logic        wake;
    pm_state_e   state;
    pm_domains_t dom;

    pm_mode_select u_sel (
        .sel_doze       (sel_doze),
        .sel_nap        (sel_nap),
        .sel_sleep      (sel_sleep),
        .ext_irq        (ext_irq),
        .smi_irq        (smi_irq),
        .core_reset_req (core_reset_req),
        .target         (target),
        .wake           (wake)
    );

    pm_sequencer #(.ENTRY_DELAY(ENTRY_DELAY)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_pwr_en  (cfg_pwr_en),
        .target      (target),
        .wake        (wake),
        .quiesce_ack (quiesce_ack),
        .state       (state),
        .pwr_en      (pwr_en)
    );

    pm_domain_decode u_dec (
        .state       (state),
        .dom         (dom),
        .quiesce_req (quiesce_req)
    );

    pm_dpm_gate #(.NUM_UNITS(NUM_UNITS)) u_dpm (
        .clk         (clk),
        .rst         (rst),
        .dpm_en      (dpm_en),
        .unit_idle   (unit_idle),
        .unit_lowpwr (unit_lowpwr)
    );

    assign pm_state    = state;
    assign core_clk_en = dom.core;
    assign pll_en      = dom.pll;
    assign tbase_en    = dom.tbase;
    assign snoop_en    = dom.snoop;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
    parameter int NUM_UNITS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 sel_sleep,
    input logic                 quiesce_ack,
    input logic                 ext_irq,
    input logic                 smi_irq,
    input logic                 core_reset_req,
    input logic                 dpm_en,
    input logic [NUM_UNITS-1:0] unit_idle,
    input logic [2:0]           pm_state,
    input logic                 pwr_en,
    input logic                 quiesce_req,
    input logic                 core_clk_en,
    input logic                 pll_en,
    input logic                 tbase_en,
    input logic                 snoop_en,
    input logic [NUM_UNITS-1:0] unit_lowpwr
);
    logic wk;
    assign wk = ext_irq | smi_irq | core_reset_req;

    assert_disabled_stays_run_R2: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 3'd0 && !pwr_en) |=> pm_state == 3'd0);

    assert_doze_domains_R3: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 3'd1) |-> (!core_clk_en && pll_en && tbase_en && snoop_en));

    assert_nap_domains_R4: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 3'd3) |-> (!core_clk_en && !snoop_en && pll_en && tbase_en));

    assert_qwait_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 3'd4 && !quiesce_ack && !wk) |=> (pm_state == 3'd4 && quiesce_req));

    assert_sleep_domains_R6: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 3'd6) |-> (quiesce_req && !core_clk_en && !pll_en && !tbase_en && !snoop_en));

    assert_sleep_first_R7: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 3'd0 && pwr_en && sel_sleep && !wk) |=> pm_state == 3'd4);

    assert_wake_to_run_R8: assert property (@(posedge clk) disable iff (rst)
        wk |=> (pm_state == 3'd0 && !pwr_en && !quiesce_req));

    assert_dpm_follow_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> unit_lowpwr == ($past(unit_idle) & {NUM_UNITS{$past(dpm_en)}}));

    assert_sleep_held_R10: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 3'd6 && !wk) |=> pm_state == 3'd6);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .sel_sleep      (sel_sleep),
    .quiesce_ack    (quiesce_ack),
    .ext_irq        (ext_irq),
    .smi_irq        (smi_irq),
    .core_reset_req (core_reset_req),
    .dpm_en         (dpm_en),
    .unit_idle      (unit_idle),
    .pm_state       (pm_state),
    .pwr_en         (pwr_en),
    .quiesce_req    (quiesce_req),
    .core_clk_en    (core_clk_en),
    .pll_en         (pll_en),
    .tbase_en       (tbase_en),
    .snoop_en       (snoop_en),
    .unit_lowpwr    (unit_lowpwr)
);

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;
    localparam int NU = 4;
    localparam int DLY = 4;

    logic clk = 1'b0;
    logic rst, cfg_we, cfg_pwr_en, sel_doze, sel_nap, sel_sleep, quiesce_ack;
    logic ext_irq, smi_irq, core_reset_req, dpm_en;
    logic [NU-1:0] unit_idle, unit_lowpwr;
    logic [2:0] pm_state;
    logic pwr_en, quiesce_req, core_clk_en, pll_en, tbase_en, snoop_en;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    pwr_mode_ctrl #(.NUM_UNITS(NU), .ENTRY_DELAY(DLY)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_pwr_en(cfg_pwr_en),
        .sel_doze(sel_doze), .sel_nap(sel_nap), .sel_sleep(sel_sleep),
        .quiesce_ack(quiesce_ack), .ext_irq(ext_irq), .smi_irq(smi_irq),
        .core_reset_req(core_reset_req), .dpm_en(dpm_en), .unit_idle(unit_idle),
        .pm_state(pm_state), .pwr_en(pwr_en), .quiesce_req(quiesce_req),
        .core_clk_en(core_clk_en), .pll_en(pll_en), .tbase_en(tbase_en),
        .snoop_en(snoop_en), .unit_lowpwr(unit_lowpwr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] doms();
        return {core_clk_en, pll_en, tbase_en, snoop_en};
    endfunction

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_we = 0; cfg_pwr_en = 0; sel_doze = 0; sel_nap = 0;
        sel_sleep = 0; quiesce_ack = 0; ext_irq = 0; smi_irq = 0;
        core_reset_req = 0; dpm_en = 0; unit_idle = '0;
        step(2);
        rst = 1'b0;
    endtask

    // Write power-enable; returns one edge later, state still run.
    task automatic arm(input logic d, input logic n, input logic s);
        sel_doze = d; sel_nap = n; sel_sleep = s;
        cfg_we = 1'b1; cfg_pwr_en = 1'b1;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_wake(input int which);
        ext_irq = (which == 0); smi_irq = (which == 1); core_reset_req = (which == 2);
        step(1);
        ext_irq = 0; smi_irq = 0; core_reset_req = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 state", pm_state, 0);
        chk("R1 pwr_en", pwr_en, 0);
        chk("R1 qreq", quiesce_req, 0);
        chk("R1 domains", doms(), 4'hF);
        chk("R1 lowpwr", unit_lowpwr, 0);
    endtask

    task automatic t_disabled();
        do_reset();
        sel_doze = 1; sel_nap = 1; sel_sleep = 1;
        step(5);
        chk("R2 stays run", pm_state, 0);
        chk("R2 domains", doms(), 4'hF);
        cfg_we = 1; cfg_pwr_en = 1;
        step(1);
        cfg_we = 0;
        chk("R2 write lands", pwr_en, 1);
    endtask

    task automatic t_doze();
        do_reset();
        arm(1, 0, 0);
        chk("R3 still run", pm_state, 0);
        step(1);
        chk("R3 doze", pm_state, 1);
        chk("R3 domains", doms(), 4'b0111);
        sel_doze = 0; sel_sleep = 1; cfg_we = 1; cfg_pwr_en = 0;
        step(3);
        cfg_we = 0;
        chk("R10 doze held", pm_state, 1);
        pulse_wake(0);
        chk("R8 irq wake", pm_state, 0);
        chk("R8 pwr cleared", pwr_en, 0);
    endtask

    task automatic t_nap();
        do_reset();
        arm(0, 1, 0);
        step(1);
        chk("R4 nap entry", pm_state, 2);
        chk("R4 entry domains", doms(), 4'hF);
        step(DLY - 1);
        chk("R4 last entry cycle", pm_state, 2);
        step(1);
        chk("R4 nap", pm_state, 3);
        chk("R4 nap domains", doms(), 4'b0110);
        step(4);
        chk("R10 nap held", pm_state, 3);
        pulse_wake(1);
        chk("R8 smi wake", pm_state, 0);
        chk("R8 smi pwr", pwr_en, 0);
    endtask

    task automatic t_sleep();
        do_reset();
        arm(0, 0, 1);
        step(1);
        chk("R5 qwait", pm_state, 4);
        chk("R5 qreq", quiesce_req, 1);
        step(10);
        chk("R5 waits ack", pm_state, 4);
        chk("R5 domains on", doms(), 4'hF);
        quiesce_ack = 1;
        step(1);
        quiesce_ack = 0;
        chk("R6 sleep entry", pm_state, 5);
        step(DLY - 1);
        chk("R6 last entry", pm_state, 5);
        chk("R6 qreq entry", quiesce_req, 1);
        step(1);
        chk("R6 sleep", pm_state, 6);
        chk("R6 domains off", doms(), 4'h0);
        chk("R6 qreq held", quiesce_req, 1);
        pulse_wake(2);
        chk("R8 reset wake", pm_state, 0);
        chk("R8 qreq drop", quiesce_req, 0);
        chk("R8 reset pwr", pwr_en, 0);
    endtask

    task automatic t_abort();
        do_reset();
        arm(0, 0, 1);
        step(2);
        chk("R5 qwait abort setup", pm_state, 4);
        ext_irq = 1; quiesce_ack = 1;
        step(1);
        ext_irq = 0; quiesce_ack = 0;
        chk("R8 abort run", pm_state, 0);
        chk("R8 abort qreq", quiesce_req, 0);
        chk("R8 abort pwr", pwr_en, 0);
        step(3);
        chk("R2 no reentry", pm_state, 0);
        // Wake beats a same-cycle write.
        cfg_we = 1; cfg_pwr_en = 1; smi_irq = 1;
        step(1);
        cfg_we = 0; smi_irq = 0;
        chk("R8 wake over write", pwr_en, 0);
    endtask

    task automatic t_priority();
        do_reset();
        arm(1, 1, 1);
        step(1);
        chk("R7 sleep wins", pm_state, 4);
        pulse_wake(0);
        arm(1, 1, 0);
        step(1);
        chk("R7 nap over doze", pm_state, 2);
        pulse_wake(0);
        arm(0, 0, 0);
        step(2);
        chk("R7 none stays run", pm_state, 0);
    endtask

    task automatic t_dpm();
        do_reset();
        dpm_en = 1; unit_idle = 4'b1010;
        step(1);
        chk("R9 idle units", unit_lowpwr, 4'b1010);
        unit_idle = 4'b0111;
        step(1);
        chk("R9 follows idle", unit_lowpwr, 4'b0111);
        dpm_en = 0;
        step(1);
        chk("R9 disabled", unit_lowpwr, 0);
        dpm_en = 1; unit_idle = 4'b1100;
        arm(1, 0, 0);
        step(1);
        chk("R9 in doze", unit_lowpwr, 4'b1100);
        chk("R9 doze state", pm_state, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_disabled();
        t_doze();
        t_nap();
        t_sleep();
        t_abort();
        t_priority();
        t_dpm();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule